// File: doc/BRIEF.md
# PWM Output Fault Conditioning Stage

This block sits between a compare/PWM waveform generator and an output pin. It takes the raw PWM level and produces the final pin level and a pin output-enable. On the way it stretches the trailing edge by a fine delay in quarter-cycle steps, optionally inverts the level, and applies a fault override that forces a configured pin level. The override releases under one of two selectable policies: at the next period start, or after software clears a latched fault flag. A tri-state control can also take the pin away from the block.

The block runs on a single phase clock that is four times the PWM cycle rate, with a parameterised number of sub-phases per cycle. An internal phase counter marks the last sub-phase of each cycle. At that edge the cycle-rate inputs (raw level, fault input, period-start strobe, fault-clear strobe, delay code and mode) are sampled. Their effect appears across the sub-phases of the cycle that follows. The phase counter starts from zero at reset, so the first sampling edge is the fourth rising clock edge after reset is released. The configuration bits for inversion, fault level, fault drive and tri-state act directly on the outputs.

Top module: `pwm_out_cond`

## Requirements
- R1: While reset is asserted, and after it until the first sampling edge, pin_out is 0 and flt_flag is 0. pin_oe equals the inverse of ctl_hiz.
- R2: With no override, no inversion and delay code 0, pin_out holds the pwm_raw value sampled at a cycle boundary for all four sub-phases of the next cycle.
- R3: When the sampled raw level goes from 1 to 0, pin_out stays 1 for the first N sub-phases of the falling cycle and is 0 after that. N is the value of ctl_dly sampled at the same edge: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives 2, 2'b11 gives 3. A raw rise is never delayed.
- R4: With ctl_inv = 1, pin_out is the complement of the delayed level. The fine delay therefore postpones the pin's rising edge, and the pin's falling edge is immediate.
- R5: When ctl_mode sampled at the falling edge equals 3'b001, the delay code has no effect and the falling cycle shows no stretch.
- R6: flt_flag sets at the sampling edge where flt_in is 1. It clears only at a sampling edge where flt_clr is 1 and flt_in is 0.
- R7: While the override is active, pin_out equals ctl_flt_lvl in every sub-phase. The override becomes active at the sampling edge where flt_in is 1.
- R8: With ctl_flt_hold = 0, the override stays active until a sampling edge at which flt_in is 0 and prd_start is 1.
- R9: With ctl_flt_hold = 1, the override stays active until flt_flag is cleared. prd_start then has no effect.
- R10: With ctl_hiz = 0, pin_oe is 1. With ctl_hiz = 1, pin_oe is 0 unless the override is active and ctl_flt_drive is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ph | input | 1 | Sub-phase clock, four times the PWM cycle rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_raw | input | 1 | Raw PWM level from the generator |
| flt_in | input | 1 | Fault input, active high |
| prd_start | input | 1 | New PWM period strobe |
| flt_clr | input | 1 | Software fault flag clear strobe |
| ctl_mode | input | 3 | Generator mode code; 3'b001 disables the fine delay |
| ctl_dly | input | 2 | Fine delay code in quarter-cycle steps |
| ctl_inv | input | 1 | Invert the output |
| ctl_flt_hold | input | 1 | Release policy: 0 at period start, 1 after flag clear |
| ctl_flt_lvl | input | 1 | Pin level forced during a fault |
| ctl_flt_drive | input | 1 | Force the pin to be an output during a fault |
| ctl_hiz | input | 1 | Tri-state the pin |
| pin_out | output | 1 | Final pin level |
| pin_oe | output | 1 | Pin output enable |
| flt_flag | output | 1 | Latched fault status |

## Verification
The bench builds the block with its default parameters: a 2-bit delay code (four sub-phases per cycle), a 3-bit mode field and single-compare code 3'b001. With these values every delay code can be observed one sub-phase at a time, in both polarities. The single-compare bypass can be compared against a full three-quarter stretch. Both release policies are driven through their boundary strobes: a period start while the fault is still present, and a clear while the fault is still present.

// File: rtl/pwm_oc_pkg.sv
package pwm_oc_pkg;
   // cycle-rate fault controls captured at a cycle boundary
   typedef struct packed {
      logic flt;
      logic prd;
      logic clr;
   } flt_smp_t;

   localparam int unsigned MAX_DLY_W = 4;
endpackage

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen #(
   parameter int unsigned DLY_W = 2,
   localparam int unsigned PH_W = (DLY_W > 0) ? DLY_W : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] ph,
   output logic            cyc_edge
);
   generate
      if (DLY_W == 0) begin : g_nophase
         assign ph       = '0;
         assign cyc_edge = 1'b1;
      end else begin : g_phase
         logic [PH_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else        cnt <= cnt + 1'b1;
         end
         assign ph       = cnt;
         assign cyc_edge = (cnt == {PH_W{1'b1}});
      end
   endgenerate
endmodule

// File: rtl/pwm_fine_dly.sv
module pwm_fine_dly #(
   parameter int unsigned DLY_W = 2,
   localparam int unsigned PH_W = (DLY_W > 0) ? DLY_W : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cyc_edge,
   input  logic [PH_W-1:0] ph,
   input  logic            raw,
   input  logic [PH_W-1:0] code,
   input  logic            bypass,
   output logic            lvl
);
   logic            cur_q;
   logic            prev_q;
   logic [PH_W-1:0] dly_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= 1'b0;
         prev_q <= 1'b0;
         dly_q  <= '0;
      end else if (cyc_edge) begin
         prev_q <= cur_q;
         cur_q  <= raw;
         dly_q  <= bypass ? '0 : code;
      end
   end

   generate
      if (DLY_W == 0) begin : g_flat
         assign lvl = cur_q;
      end else begin : g_stretch
         // a fall is held high for the first dly_q sub-phases
         assign lvl = cur_q | (prev_q & (ph < dly_q));
      end
   endgenerate
endmodule

// File: rtl/pwm_fault_ctl.sv
module pwm_fault_ctl
   import pwm_oc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cyc_edge,
   input  flt_smp_t smp,
   input  logic     hold_sw,
   output logic     flag,
   output logic     active
);
   logic flag_nx;
   logic act_nx;

   always_comb begin
      flag_nx = smp.flt | (flag & ~smp.clr);
      if (hold_sw) act_nx = smp.flt | (active & flag_nx);
      else         act_nx = smp.flt | (active & ~smp.prd);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag   <= 1'b0;
         active <= 1'b0;
      end else if (cyc_edge) begin
         flag   <= flag_nx;
         active <= act_nx;
      end
   end
endmodule

// File: rtl/pwm_out_cond.sv
module pwm_out_cond
   import pwm_oc_pkg::*;
#(
   parameter int unsigned DLY_W       = 2,
   parameter int unsigned MODE_W      = 3,
   parameter int unsigned MODE_SINGLE = 1,
   localparam int unsigned PH_W = (DLY_W > 0) ? DLY_W : 1
) (
   input  logic              clk_ph,
   input  logic              rst_n,
   input  logic              pwm_raw,
   input  logic              flt_in,
   input  logic              prd_start,
   input  logic              flt_clr,
   input  logic [MODE_W-1:0] ctl_mode,
   input  logic [PH_W-1:0]   ctl_dly,
   input  logic              ctl_inv,
   input  logic              ctl_flt_hold,
   input  logic              ctl_flt_lvl,
   input  logic              ctl_flt_drive,
   input  logic              ctl_hiz,
   output logic              pin_out,
   output logic              pin_oe,
   output logic              flt_flag
);
   generate
      if (DLY_W > MAX_DLY_W) begin : g_bad_dly
         $error("DLY_W exceeds MAX_DLY_W");
      end
      if (MODE_SINGLE >= (1 << MODE_W)) begin : g_bad_mode
         $error("MODE_SINGLE does not fit in MODE_W bits");
      end
   endgenerate

   localparam logic [MODE_W-1:0] SINGLE_CODE = MODE_W'(MODE_SINGLE);

   logic [PH_W-1:0] ph;
   logic            cyc_edge;
   logic            fine_lvl;
   logic            pol_lvl;
   logic            flt_act;
   flt_smp_t        smp;

   assign smp = '{flt: flt_in, prd: prd_start, clr: flt_clr};

   pwm_phase_gen #(.DLY_W(DLY_W)) u_phase (
      .clk      (clk_ph),
      .rst_n    (rst_n),
      .ph       (ph),
      .cyc_edge (cyc_edge)
   );

   pwm_fine_dly #(.DLY_W(DLY_W)) u_dly (
      .clk      (clk_ph),
      .rst_n    (rst_n),
      .cyc_edge (cyc_edge),
      .ph       (ph),
      .raw      (pwm_raw),
      .code     (ctl_dly),
      .bypass   (ctl_mode == SINGLE_CODE),
      .lvl      (fine_lvl)
   );

   pwm_fault_ctl u_fault (
      .clk      (clk_ph),
      .rst_n    (rst_n),
      .cyc_edge (cyc_edge),
      .smp      (smp),
      .hold_sw  (ctl_flt_hold),
      .flag     (flt_flag),
      .active   (flt_act)
   );

   // inversion first, so the fault level is the true pin level
   assign pol_lvl = fine_lvl ^ ctl_inv;
   assign pin_out = flt_act ? ctl_flt_lvl : pol_lvl;
   assign pin_oe  = ~ctl_hiz | (flt_act & ctl_flt_drive);
endmodule

// File: rtl/pwm_oc_chk.sv
module pwm_oc_chk (
   input logic clk_ph,
   input logic rst_n,
   input logic cyc_edge,
   input logic flt_in,
   input logic prd_start,
   input logic flt_clr,
   input logic ctl_flt_hold,
   input logic ctl_flt_lvl,
   input logic ctl_hiz,
   input logic flt_act,
   input logic flt_flag,
   input logic pin_out,
   input logic pin_oe
);
   a_r6_flag_sets: assert property (@(posedge clk_ph) disable iff (!rst_n)
      (cyc_edge && flt_in) |=> flt_flag);
   a_r6_flag_steady: assert property (@(posedge clk_ph) disable iff (!rst_n)
      (!cyc_edge) |=> $stable(flt_flag));
   a_r6_flag_kept: assert property (@(posedge clk_ph) disable iff (!rst_n)
      (cyc_edge && flt_flag && !flt_clr) |=> flt_flag);
   a_r7_override_on: assert property (@(posedge clk_ph) disable iff (!rst_n)
      (cyc_edge && flt_in) |=> flt_act);
   a_r7_forced_level: assert property (@(posedge clk_ph) disable iff (!rst_n)
      flt_act |-> (pin_out == ctl_flt_lvl));
   a_r8_wait_period: assert property (@(posedge clk_ph) disable iff (!rst_n)
      (cyc_edge && !ctl_flt_hold && flt_act && !prd_start) |=> flt_act);
   a_r10_driven: assert property (@(posedge clk_ph) disable iff (!rst_n)
      (!ctl_hiz) |-> pin_oe);
   a_r10_released: assert property (@(posedge clk_ph) disable iff (!rst_n)
      (ctl_hiz && !flt_act) |-> !pin_oe);
endmodule

bind pwm_out_cond pwm_oc_chk u_chk (
   .clk_ph       (clk_ph),
   .rst_n        (rst_n),
   .cyc_edge     (cyc_edge),
   .flt_in       (flt_in),
   .prd_start    (prd_start),
   .flt_clr      (flt_clr),
   .ctl_flt_hold (ctl_flt_hold),
   .ctl_flt_lvl  (ctl_flt_lvl),
   .ctl_hiz      (ctl_hiz),
   .flt_act      (flt_act),
   .flt_flag     (flt_flag),
   .pin_out      (pin_out),
   .pin_oe       (pin_oe)
);

// File: tb/sim_pwm_out_cond.sv
module sim_pwm_out_cond;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwm_raw = 1'b0, flt_in = 1'b0, prd_start = 1'b0, flt_clr = 1'b0;
   logic [2:0] ctl_mode = 3'b110;
   logic [1:0] ctl_dly = 2'b00;
   logic       ctl_inv = 1'b0, ctl_flt_hold = 1'b0, ctl_flt_lvl = 1'b0;
   logic       ctl_flt_drive = 1'b0, ctl_hiz = 1'b1;
   logic       pin_out, pin_oe, flt_flag;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [3:0] pv, ov;
   logic       fl;

   always #(CLK_P/2) clk = ~clk;

   pwm_out_cond u0 (
      .clk_ph(clk), .rst_n(rst_n), .pwm_raw(pwm_raw), .flt_in(flt_in),
      .prd_start(prd_start), .flt_clr(flt_clr), .ctl_mode(ctl_mode),
      .ctl_dly(ctl_dly), .ctl_inv(ctl_inv), .ctl_flt_hold(ctl_flt_hold),
      .ctl_flt_lvl(ctl_flt_lvl), .ctl_flt_drive(ctl_flt_drive),
      .ctl_hiz(ctl_hiz), .pin_out(pin_out), .pin_oe(pin_oe),
      .flt_flag(flt_flag)
   );

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // starts and ends at the falling clock edge of the last sub-phase;
   // the next rising edge samples the inputs, then four sub-phases are recorded
   task automatic cyc(input logic r, input logic f, input logic ps, input logic cl);
      pwm_raw = r; flt_in = f; prd_start = ps; flt_clr = cl;
      for (int p = 0; p < 4; p++) begin
         @(posedge clk); @(negedge clk);
         pv[p] = pin_out;
         ov[p] = pin_oe;
      end
      fl = flt_flag;
   endtask

   task automatic t_reset;
      pwm_raw = 1'b1;
      #(CLK_P*3);
      chk("R1 pin in reset", {3'b000, pin_out}, 4'b0000);
      chk("R1 flag in reset", {3'b000, flt_flag}, 4'b0000);
      chk("R1 oe in reset", {3'b000, pin_oe}, 4'b0000);
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); @(negedge clk);
         chk("R1 pin before first sample", {3'b000, pin_out}, 4'b0000);
      end
      ctl_hiz = 1'b0;
      #1 chk("R1 oe follows hiz", {3'b000, pin_oe}, 4'b0001);
   endtask

   task automatic t_follow;
      cyc(1, 0, 0, 0); chk("R2 high", pv, 4'b1111);
      cyc(0, 0, 0, 0); chk("R2 low", pv, 4'b0000);
      cyc(1, 0, 0, 0); chk("R2 high again", pv, 4'b1111);
      cyc(1, 0, 0, 0); chk("R2 steady high", pv, 4'b1111);
   endtask

   task automatic t_delay;
      for (int d = 0; d < 4; d++) begin
         ctl_dly = 2'(d);
         cyc(1, 0, 0, 0);
         cyc(0, 0, 0, 0);
         chk($sformatf("R3 stretch code %0d", d), pv, 4'((1 << d) - 1));
      end
      ctl_dly = 2'b11;
      cyc(1, 0, 0, 0); chk("R3 rise not delayed", pv, 4'b1111);
      ctl_dly = 2'b00;
      cyc(0, 0, 0, 0);
   endtask

   task automatic t_invert;
      ctl_inv = 1'b1; ctl_dly = 2'b01;
      cyc(0, 0, 0, 0); chk("R4 inverted low raw", pv, 4'b1111);
      cyc(1, 0, 0, 0); chk("R4 pin fall immediate", pv, 4'b0000);
      cyc(0, 0, 0, 0); chk("R4 pin rise delayed", pv, 4'b1110);
      ctl_inv = 1'b0; ctl_dly = 2'b00;
      cyc(0, 0, 0, 0);
   endtask

   task automatic t_single;
      ctl_mode = 3'b001; ctl_dly = 2'b11;
      cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0); chk("R5 no stretch in single mode", pv, 4'b0000);
      ctl_inv = 1'b1;
      cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0); chk("R5 no stretch inverted", pv, 4'b1111);
      ctl_inv = 1'b0; ctl_mode = 3'b110; ctl_dly = 2'b00;
      cyc(0, 0, 0, 0);
   endtask

   task automatic t_fault_period;
      ctl_flt_hold = 1'b0; ctl_flt_lvl = 1'b1;
      cyc(0, 0, 0, 0); chk("R6 flag idle", {3'b000, fl}, 4'b0000);
      cyc(0, 1, 0, 0);
      chk("R6 flag set", {3'b000, fl}, 4'b0001);
      chk("R7 forced high", pv, 4'b1111);
      cyc(0, 1, 1, 0); chk("R8 period with fault present", pv, 4'b1111);
      cyc(0, 0, 0, 0); chk("R8 fault gone no period", pv, 4'b1111);
      cyc(0, 0, 1, 0); chk("R8 released at period", pv, 4'b0000);
      chk("R6 flag survives release", {3'b000, fl}, 4'b0001);
      cyc(0, 0, 0, 1); chk("R6 flag cleared", {3'b000, fl}, 4'b0000);
      ctl_flt_lvl = 1'b0;
      cyc(1, 1, 0, 0); chk("R7 forced low", pv, 4'b0000);
      cyc(1, 0, 1, 1); chk("R8 released raw high", pv, 4'b1111);
   endtask

   task automatic t_fault_sticky;
      ctl_flt_hold = 1'b1; ctl_flt_lvl = 1'b0;
      cyc(1, 1, 0, 0); chk("R7 sticky forced low", pv, 4'b0000);
      cyc(1, 1, 0, 1);
      chk("R6 clear ignored while fault", {3'b000, fl}, 4'b0001);
      chk("R9 still forced", pv, 4'b0000);
      cyc(1, 0, 1, 0); chk("R9 period ignored", pv, 4'b0000);
      cyc(1, 0, 0, 1);
      chk("R9 released by clear", pv, 4'b1111);
      chk("R6 flag clear", {3'b000, fl}, 4'b0000);
   endtask

   task automatic t_oe;
      ctl_flt_hold = 1'b1; ctl_hiz = 1'b1; ctl_flt_drive = 1'b1;
      cyc(0, 0, 0, 0); chk("R10 hiz no fault", ov, 4'b0000);
      cyc(0, 1, 0, 0); chk("R10 fault drives pin", ov, 4'b1111);
      ctl_flt_drive = 1'b0;
      cyc(0, 1, 0, 0); chk("R10 fault without drive", ov, 4'b0000);
      ctl_hiz = 1'b0;
      cyc(0, 1, 0, 0); chk("R10 not hiz", ov, 4'b1111);
      cyc(0, 0, 0, 1);
      ctl_hiz = 1'b1; ctl_flt_drive = 1'b1;
      cyc(0, 0, 0, 0); chk("R10 released fault", ov, 4'b0000);
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_follow();
      t_delay();
      t_invert();
      t_single();
      t_fault_period();
      t_fault_sticky();
      t_oe();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule